// File: doc/BRIEF.md
# Two-Port Register-Mapped Pin Controller

The block is a small register file on a word-indexed read/write bus that drives two eight-or-wider pin ports, called A and D. Each port has a stored output value, a stored enable mask and a read-only input view. The input view returns the stored output ANDed with the enable mask. One status line from an attached peripheral is ORed into a fixed bit of that view.

Selected bits of the port A output register act as control strobes for an attached NAND flash device. Bit 1 of the port D output register is the serial clock of a bit-banged temperature sensor. Whenever a write to port D changes that bit, the block raises a one-cycle clock-edge event and reports the edge direction.

The flash ready line comes back on port A, and the sensor's serial data output comes back on port D. Neither peripheral is part of the block. Their lines appear as ports of the block.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset all stored registers are zero. All pin enables, pin values, flash strobes, the sensor event and direction, and the read data are low.
- R2: Index 0x00 holds the port A output, index 0x02 the port A enable, index 0x10 the port D output and index 0x12 the port D enable. A write stores the full data word there, and the stored values drive the matching pin outputs from the cycle after the write.
- R3: A read captures the addressed word on the clock edge of the request. `bus_rdata` shows it from that edge until the next read. Reads of indices 0x00, 0x02, 0x10 and 0x12 return the stored word.
- R4: Index 0x01 reads as (port A output AND port A enable), with bit 7 ORed with `flash_rdy`.
- R5: Index 0x11 reads as (port D output AND port D enable), with bit 4 ORed with `sens_sdo`.
- R6: `flash_ale`, `flash_cle` and `flash_ce` follow bits 6, 5 and 4 of the stored port A output. They change only in the cycle after a write to index 0x00.
- R7: A write to index 0x10 whose bit 1 differs from the stored bit 1 makes `sens_edge` high for the following cycle. In that cycle `sens_rise` equals the new bit 1. A write that keeps bit 1 produces no event and leaves `sens_rise` unchanged.
- R8: Writes to the input indices 0x01 and 0x11, and to any index other than the four stored ones, change no register and no pin. Reads of any index other than the six named ones return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | IDX_W | Word index in the register window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| porta_out | output | DW | Port A pin values |
| porta_oe | output | DW | Port A pin enables |
| portd_out | output | DW | Port D pin values |
| portd_oe | output | DW | Port D pin enables |
| flash_ale | output | 1 | Flash address latch strobe |
| flash_cle | output | 1 | Flash command latch strobe |
| flash_ce | output | 1 | Flash chip enable |
| flash_rdy | input | 1 | Flash ready status |
| sens_sdo | input | 1 | Sensor serial data output |
| sens_edge | output | 1 | One-cycle sensor clock-edge event |
| sens_rise | output | 1 | Direction of the last edge (1 = rising) |

## Verification
A write is visible on the pins, the flash strobes and the sensor event one cycle after the clock edge that accepts it. The bench therefore drives on the falling edge and checks those outputs on the next falling edge. It checks again one cycle later to confirm that the event has cleared. A read returns its data after the single accepting edge. The driver queues the value predicted from its own register model, and the monitor pops and compares it two time units after the edge at which it sees the read request.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
   localparam int NPORT       = 2;
   localparam int IDX_A_BASE  = 'h00;
   localparam int IDX_D_BASE  = 'h10;
   localparam int OFS_OUT     = 0;
   localparam int OFS_VIEW    = 1;
   localparam int OFS_OE      = 2;
   localparam int RDY_BIT     = 7;
   localparam int SDO_BIT     = 4;
   localparam int ALE_BIT     = 6;
   localparam int CLE_BIT     = 5;
   localparam int CE_BIT      = 4;
   localparam int SCLK_BIT    = 1;

   function automatic int port_base(input int p);
      return (p == 0) ? IDX_A_BASE : IDX_D_BASE;
   endfunction

   function automatic int port_stat_bit(input int p);
      return (p == 0) ? RDY_BIT : SDO_BIT;
   endfunction
endpackage

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
   import gpio_pin_pkg::*;
#(
   parameter int DW       = 32,
   parameter int IDX_W    = 5,
   parameter int BASE     = 0,
   parameter int STAT_BIT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   input  logic             stat_in,
   output logic [DW-1:0]    dout,
   output logic [DW-1:0]    oe,
   output logic [DW-1:0]    view,
   output logic             out_wr
);
   logic oe_wr;

   assign out_wr = wr_en && (idx == IDX_W'(BASE + OFS_OUT));
   assign oe_wr  = wr_en && (idx == IDX_W'(BASE + OFS_OE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
         oe   <= '0;
      end else begin
         if (out_wr) dout <= wdata;
         if (oe_wr)  oe   <= wdata;
      end
   end

   always_comb begin
      view           = dout & oe;
      view[STAT_BIT] = view[STAT_BIT] | stat_in;
   end
endmodule

// File: rtl/gpio_clk_edge.sv
module gpio_clk_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic old_lvl,
   input  logic new_lvl,
   output logic evt,
   output logic dir
);
   logic change;
   assign change = wr_hit && (old_lvl != new_lvl);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt <= 1'b0;
         dir <= 1'b0;
      end else begin
         evt <= change;
         if (change) dir <= new_lvl;
      end
   end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
   import gpio_pin_pkg::*;
#(
   parameter int DW    = 32,
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0]          idx,
   input  logic [NPORT-1:0][DW-1:0]  dout,
   input  logic [NPORT-1:0][DW-1:0]  oe,
   input  logic [NPORT-1:0][DW-1:0]  view,
   output logic [DW-1:0]             data
);
   always_comb begin
      data = '0;
      for (int p = 0; p < NPORT; p++) begin
         if (idx == IDX_W'(port_base(p) + OFS_OUT))  data = dout[p];
         if (idx == IDX_W'(port_base(p) + OFS_VIEW)) data = view[p];
         if (idx == IDX_W'(port_base(p) + OFS_OE))   data = oe[p];
      end
   end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
   import gpio_pin_pkg::*;
#(
   parameter int DW         = 32,
   parameter int WIN_BYTES  = 'h5C,
   localparam int WORDS     = WIN_BYTES / 4,
   localparam int IDX_W     = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [IDX_W-1:0] bus_idx,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   output logic [DW-1:0]    porta_out,
   output logic [DW-1:0]    porta_oe,
   output logic [DW-1:0]    portd_out,
   output logic [DW-1:0]    portd_oe,
   output logic             flash_ale,
   output logic             flash_cle,
   output logic             flash_ce,
   input  logic             flash_rdy,
   input  logic             sens_sdo,
   output logic             sens_edge,
   output logic             sens_rise
);
   if (DW < 8) begin : g_bad_dw
      $error("gpio_pin_ctrl: DW must be at least 8");
   end
   if (WORDS <= IDX_D_BASE + OFS_OE) begin : g_bad_win
      $error("gpio_pin_ctrl: window too small for port D");
   end

   logic                      wr_en;
   logic                      rd_en;
   logic [NPORT-1:0]          stat;
   logic [NPORT-1:0]          out_wr;
   logic [NPORT-1:0][DW-1:0]  dout;
   logic [NPORT-1:0][DW-1:0]  oe;
   logic [NPORT-1:0][DW-1:0]  view;
   logic [DW-1:0]             rd_mux;

   assign wr_en = bus_sel && bus_wr;
   assign rd_en = bus_sel && !bus_wr;
   assign stat  = {sens_sdo, flash_rdy};

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      gpio_port_bank #(
         .DW       (DW),
         .IDX_W    (IDX_W),
         .BASE     (port_base(p)),
         .STAT_BIT (port_stat_bit(p))
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .idx     (bus_idx),
         .wdata   (bus_wdata),
         .stat_in (stat[p]),
         .dout    (dout[p]),
         .oe      (oe[p]),
         .view    (view[p]),
         .out_wr  (out_wr[p])
      );
   end

   gpio_clk_edge u_sclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (out_wr[1]),
      .old_lvl (dout[1][SCLK_BIT]),
      .new_lvl (bus_wdata[SCLK_BIT]),
      .evt     (sens_edge),
      .dir     (sens_rise)
   );

   gpio_rd_mux #(.DW(DW), .IDX_W(IDX_W)) u_mux (
      .idx  (bus_idx),
      .dout (dout),
      .oe   (oe),
      .view (view),
      .data (rd_mux)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_mux;
   end

   assign porta_out = dout[0];
   assign porta_oe  = oe[0];
   assign portd_out = dout[1];
   assign portd_oe  = oe[1];
   assign flash_ale = dout[0][ALE_BIT];
   assign flash_cle = dout[0][CLE_BIT];
   assign flash_ce  = dout[0][CE_BIT];
endmodule

module gpio_pin_ctrl_chk
   import gpio_pin_pkg::*;
#(
   parameter int DW    = 32,
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [IDX_W-1:0] bus_idx,
   input logic [DW-1:0]    bus_wdata,
   input logic [DW-1:0]    bus_rdata,
   input logic [DW-1:0]    porta_oe,
   input logic [DW-1:0]    portd_out,
   input logic             flash_ale,
   input logic             flash_cle,
   input logic             flash_ce,
   input logic             sens_edge,
   input logic             sens_rise
);
   logic wr_a_out, wr_d_out, wr_a_oe, rd_unmapped;
   assign wr_a_out = bus_sel && bus_wr && (bus_idx == IDX_W'(IDX_A_BASE + OFS_OUT));
   assign wr_d_out = bus_sel && bus_wr && (bus_idx == IDX_W'(IDX_D_BASE + OFS_OUT));
   assign wr_a_oe  = bus_sel && bus_wr && (bus_idx == IDX_W'(IDX_A_BASE + OFS_OE));
   assign rd_unmapped = bus_sel && !bus_wr && (bus_idx > IDX_W'(2)) &&
                        (bus_idx < IDX_W'(IDX_D_BASE) || bus_idx > IDX_W'(IDX_D_BASE + 2));

   // R6
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_a_out |=> ($stable(flash_ale) && $stable(flash_cle) && $stable(flash_ce)));

   // R7
   edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_d_out |=> !sens_edge);

   // R7
   edge_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sens_edge |-> (sens_rise == portd_out[SCLK_BIT]));

   // R7
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_d_out |=> $stable(sens_rise));

   // R2
   oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_a_oe |=> $stable(porta_oe));

   // R8
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_unmapped |=> (bus_rdata == '0));
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_idx   (bus_idx),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .porta_oe  (porta_oe),
   .portd_out (portd_out),
   .flash_ale (flash_ale),
   .flash_cle (flash_cle),
   .flash_ce  (flash_ce),
   .sens_edge (sens_edge),
   .sens_rise (sens_rise)
);

// File: tb/sim_gpio_pin_ctrl.sv
module sim_gpio_pin_ctrl;
   localparam int DW = 32;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [IW-1:0] bus_idx = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata, porta_out, porta_oe, portd_out, portd_oe;
   logic          flash_ale, flash_cle, flash_ce, sens_edge, sens_rise;
   logic          flash_rdy = 1'b0, sens_sdo = 1'b0;

   always #5 clk = ~clk;

   gpio_pin_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .porta_out(porta_out), .porta_oe(porta_oe),
      .portd_out(portd_out), .portd_oe(portd_oe),
      .flash_ale(flash_ale), .flash_cle(flash_cle), .flash_ce(flash_ce),
      .flash_rdy(flash_rdy), .sens_sdo(sens_sdo),
      .sens_edge(sens_edge), .sens_rise(sens_rise)
   );

   int nvec = 0;
   int nfail = 0;
   bit done = 1'b0;

   logic [DW-1:0] m_aout = '0, m_aoe = '0, m_dout = '0, m_doe = '0;
   logic          m_rise = 1'b0;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] model_rd(input int idx);
      logic [DW-1:0] v;
      case (idx)
         'h00: v = m_aout;
         'h01: begin v = m_aout & m_aoe; v[7] = v[7] | flash_rdy; end
         'h02: v = m_aoe;
         'h10: v = m_dout;
         'h11: begin v = m_dout & m_doe; v[4] = v[4] | sens_sdo; end
         'h12: v = m_doe;
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic do_read(input int idx, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = IW'(idx);
      exp_q.push_back(model_rd(idx));
      tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic do_write(input int idx, input logic [DW-1:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = IW'(idx); bus_wdata = v;
      case (idx)
         'h00: m_aout = v;
         'h02: m_aoe  = v;
         'h10: m_dout = v;
         'h12: m_doe  = v;
         default: ;
      endcase
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic chk_pins(input string tag);
      check({tag, " porta_out"}, porta_out, m_aout);
      check({tag, " porta_oe"},  porta_oe,  m_aoe);
      check({tag, " portd_out"}, portd_out, m_dout);
      check({tag, " portd_oe"},  portd_oe,  m_doe);
      check({tag, " strobes"}, {29'd0, flash_ale, flash_cle, flash_ce},
            {29'd0, m_aout[6], m_aout[5], m_aout[4]});
   endtask

   // monitor: pops predicted read data after the accepting edge
   always begin
      @(posedge clk);
      if (rst_n && bus_sel && !bus_wr) begin
         #2;
         if (exp_q.size() == 0) begin
            nvec++; nfail++;
            $display("FAIL R3 unexpected read actual=%h expected=none", bus_rdata);
         end else begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_pins("R1 reset");
      check("R1 reset edge/rise", {30'd0, sens_edge, sens_rise}, '0);
      check("R1 reset rdata", bus_rdata, '0);
      do_read('h01, "R1 view A after reset");
      do_read('h12, "R1 oe D after reset");

      // R6 strobes
      do_write('h00, 32'h0000_0070);
      chk_pins("R6 all strobes");
      do_write('h00, 32'h0000_0020);
      chk_pins("R6 cle only");
      do_write('h00, 32'h0000_0050);
      chk_pins("R6 ale+ce");

      // R2 R3 readback
      do_write('h02, 32'hF0F0_00F0);
      do_write('h12, 32'h0000_FFFF);
      chk_pins("R2 enables");
      do_read('h00, "R3 read A out");
      do_read('h02, "R3 read A oe");
      do_read('h12, "R3 read D oe");

      // R4 view and ready bit
      do_read('h01, "R4 view A rdy=0");
      flash_rdy = 1'b1;
      do_read('h01, "R4 view A rdy=1");
      do_write('h00, 32'hFFFF_FF7F);
      do_read('h01, "R4 view A masked rdy=1");
      flash_rdy = 1'b0;
      do_read('h01, "R4 view A masked rdy=0");

      // R7 sensor clock edges
      do_write('h10, 32'h0000_0002);
      m_rise = 1'b1;
      check("R7 rise event", {30'd0, sens_edge, sens_rise}, {30'd0, 1'b1, m_rise});
      @(negedge clk);
      check("R7 event clears", {31'd0, sens_edge}, '0);
      do_write('h10, 32'h0000_0016);
      check("R7 same level no event", {30'd0, sens_edge, sens_rise}, {30'd0, 1'b0, m_rise});
      do_write('h10, 32'h0000_0010);
      m_rise = 1'b0;
      check("R7 fall event", {30'd0, sens_edge, sens_rise}, {30'd0, 1'b1, m_rise});
      chk_pins("R7 pins");

      // R5 sensor data bit
      do_read('h11, "R5 view D sdo=0");
      sens_sdo = 1'b1;
      do_read('h11, "R5 view D sdo=1");
      do_write('h12, 32'h0000_0000);
      do_read('h11, "R5 view D oe=0 sdo=1");
      sens_sdo = 1'b0;
      do_read('h10, "R3 read D out");

      // R8 ignored writes, unmapped reads
      do_write('h01, 32'hDEAD_BEEF);
      chk_pins("R8 write idx 01");
      check("R8 no edge idx 01", {31'd0, sens_edge}, '0);
      do_write('h11, 32'hFFFF_FFFF);
      chk_pins("R8 write idx 11");
      do_write('h05, 32'h1234_5678);
      do_write('h13, 32'h0000_0002);
      chk_pins("R8 write unmapped");
      check("R8 no edge unmapped", {31'd0, sens_edge}, '0);
      do_read('h05, "R8 read 05");
      do_read('h13, "R8 read 13");
      do_read('h16, "R8 read 16");
      do_read('h1F, "R8 read 1F");
      do_read('h00, "R8 A out intact");
      do_read('h10, "R8 D out intact");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         nvec++; nfail++;
         $display("FAIL R3 reads pending actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule